// File: doc/BRIEF.md
# SMBus Host Register Engine

This block is the software-facing side of an SMBus host. Software uses a byte-wide register port to load a target address and direction, a command byte, two data bytes and a 32-byte block buffer. It then writes the control register with the start bit set. The sequencer issues one transaction of the selected protocol to a downstream target port. The port has a valid/ready request and a response that returns read data, a block count, a block payload and an error flag.

Read results go back into the data registers and the block buffer. A status register reports busy, done and device error. Quick, byte, word, send/receive and block protocols are supported. Other protocol codes are rejected locally and raise the error flag. The wire-level SCL/SDA signalling is handled by whatever sits behind the target port.

Top module: `smb_host_regs`

## Requirements
- R1: Only the low 6 bits of the register address are decoded, so addresses repeat every 64. The register offsets are:
  - 0: status
  - 2: control
  - 3: command
  - 4: address
  - 5: data0
  - 6: data1
  - 7: block data

  Offset 1 and offsets 8 to 63 read as 0.
- R2: A control write with bit 6 set while idle starts a transaction.
  - The protocol comes from control bits 4:2: 0 quick, 1 send/receive byte, 2 byte, 3 word, 5 block.
  - The request carries address bits 7:1 as the target and address bit 0 as the direction (1 = read), plus the command byte, {data1,data0}, data0 as the block count and the buffer.
  - Starting a transaction sets busy (status bit 0) and clears done and error.
- R3: The request valid signal stays high until ready is seen and drops in the next cycle. Busy stays set until the response arrives.
- R4: When the response arrives, busy clears. Done (status bit 1) is set when the error flag is low; otherwise device error (status bit 2) is set.
- R5: A successful read updates the data registers:
  - receive byte and byte read: data0 takes response bits 7:0;
  - word read: data0 takes the low byte and data1 the high byte.

  Write transactions leave the data registers unchanged.
- R6: A block transaction sends data0 as the byte count and the 32-byte buffer as the payload. A successful block read writes the returned count into data0 and the returned payload into the buffer.
- R7: Each read or write at offset 7 accesses buffer[index] and then increments the index. After 31 the index wraps to 0.
- R8: Any write to status clears done and error and resets the index to 0. A read of control resets the index to 0 and returns only control bits 4:0, with bits 7:5 read as 0.
- R9: A start with protocol code 4, 6 or 7 sends no request, sets the error bit in the next cycle and leaves busy clear.
- R10: While busy, a control write is ignored entirely: it starts nothing and the stored control value is kept.
- R11: After reset, every register, the status flags and the buffer index are 0 and no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (drives index side effects) |
| reg_addr_i | input | ADDR_W | Register address, decoded modulo 64 |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| req_valid_o | output | 1 | Transaction request valid |
| req_ready_i | input | 1 | Target accepts request |
| req_addr_o | output | 7 | Target device address |
| req_read_o | output | 1 | Direction, 1 = read |
| req_proto_o | output | 3 | Protocol code |
| req_cmd_o | output | 8 | Command byte |
| req_data_o | output | 16 | {data1, data0} |
| req_count_o | output | 8 | Block byte count (data0) |
| req_blk_o | output | BLK_DEPTH*8 | Block payload, byte i at bits 8i+7:8i |
| rsp_valid_i | input | 1 | Response valid |
| rsp_err_i | input | 1 | Absent device or failed transfer |
| rsp_data_i | input | 16 | Read data, low byte in bits 7:0 |
| rsp_count_i | input | 8 | Returned block count |
| rsp_blk_i | input | BLK_DEPTH*8 | Returned block payload |

## Verification
The bench checks the buffer index wrap from 31 to 0. A design that saturated the index, or wrapped it early, would return the wrong byte on the 33rd access. It also checks that reading control clears the index while reading other registers does not; getting that wrong would shift every later block byte.

A start issued while a stalled request is outstanding must leave both the control value and the request count unchanged. A design that took the second start would overwrite the protocol field or issue a second request. The bench also checks that an unsupported protocol code sets the error bit with no downstream request, that a transaction to an absent target sets error rather than done, and that a write leaves data0 unchanged. A design with the wrong result muxing would corrupt data0 after a write.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int DW = 8;

  localparam logic [5:0] OFF_STS = 6'd0;
  localparam logic [5:0] OFF_CTL = 6'd2;
  localparam logic [5:0] OFF_CMD = 6'd3;
  localparam logic [5:0] OFF_ADR = 6'd4;
  localparam logic [5:0] OFF_D0  = 6'd5;
  localparam logic [5:0] OFF_D1  = 6'd6;
  localparam logic [5:0] OFF_BLK = 6'd7;

  localparam int CTL_START = 6;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_SRBYTE = 3'd1;
  localparam logic [2:0] PR_BYTE = 3'd2;
  localparam logic [2:0] PR_WORD = 3'd3;
  localparam logic [2:0] PR_BLOCK = 3'd5;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_st_e;

  function automatic logic proto_ok(input logic [2:0] p);
    return (p == PR_QUICK) || (p == PR_SRBYTE) || (p == PR_BYTE) ||
           (p == PR_WORD) || (p == PR_BLOCK);
  endfunction
endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_wr_i,
  input  logic                 acc_rd_i,
  input  logic [7:0]           wdata_i,
  input  logic                 idx_clr_i,
  input  logic                 load_i,
  input  logic [DEPTH*8-1:0]   load_data_i,
  output logic [7:0]           rdata_o,
  output logic [DEPTH*8-1:0]   flat_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_nxt;

  assign idx_nxt = (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_clr_i) idx_q <= '0;
    else if (acc_wr_i || acc_rd_i) idx_q <= idx_nxt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (load_i) mem_q[g] <= load_data_i[g*8 +: 8];
      else if (acc_wr_i && !idx_clr_i && idx_q == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
    assign flat_o[g*8 +: 8] = mem_q[g];
  end

  assign rdata_o = mem_q[idx_q];
  assign idx_o   = idx_q;
endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] proto_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  output logic       req_valid_o,
  output logic       busy_o,
  output logic       fin_o,
  output logic       bad_o
);
  seq_st_e st_q, st_d;
  logic    go;

  assign go    = start_i && proto_ok(proto_i);
  assign bad_o = start_i && !proto_ok(proto_i);
  assign fin_o = (st_q == SQ_WAIT) && rsp_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (go) st_d = SQ_REQ;
      SQ_REQ:  if (req_ready_i) st_d = SQ_WAIT;
      SQ_WAIT: if (rsp_valid_i) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else st_q <= st_d;
  end

  assign req_valid_o = (st_q == SQ_REQ);
  assign busy_o      = (st_q != SQ_IDLE);
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_DEPTH = 32,
  localparam int IDX_W = $clog2(BLK_DEPTH),
  localparam int BLK_W = BLK_DEPTH * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [6:0]        req_addr_o,
  output logic              req_read_o,
  output logic [2:0]        req_proto_o,
  output logic [7:0]        req_cmd_o,
  output logic [15:0]       req_data_o,
  output logic [7:0]        req_count_o,
  output logic [BLK_W-1:0]  req_blk_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [15:0]       rsp_data_i,
  input  logic [7:0]        rsp_count_i,
  input  logic [BLK_W-1:0]  rsp_blk_i
);
  logic [5:0]       off;
  logic [7:0]       ctl_q, cmd_q, adr_q, d0_q, d1_q;
  logic             done_q, err_q;
  logic             busy_w, fin_w, bad_w, start_w;
  logic             wr_sts, wr_ctl, rd_ctl, ok_rd, blk_load;
  logic [7:0]       blk_rdata;
  logic [IDX_W-1:0] idx_w;

  assign off     = reg_addr_i[5:0];
  assign wr_sts  = reg_wr_i && off == OFF_STS;
  assign wr_ctl  = reg_wr_i && off == OFF_CTL;
  assign rd_ctl  = reg_rd_i && off == OFF_CTL;
  assign start_w = wr_ctl && reg_wdata_i[CTL_START] && !busy_w;
  assign ok_rd   = fin_w && !rsp_err_i && adr_q[0];
  assign blk_load = ok_rd && ctl_q[4:2] == PR_BLOCK;

  smb_seq u_seq (
    .clk_i, .rst_ni,
    .start_i(start_w), .proto_i(reg_wdata_i[4:2]),
    .req_ready_i, .rsp_valid_i,
    .req_valid_o, .busy_o(busy_w), .fin_o(fin_w), .bad_o(bad_w)
  );

  smb_blk_buf #(.DEPTH(BLK_DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .acc_wr_i(reg_wr_i && off == OFF_BLK),
    .acc_rd_i(reg_rd_i && off == OFF_BLK),
    .wdata_i(reg_wdata_i),
    .idx_clr_i(wr_sts || rd_ctl),
    .load_i(blk_load),
    .load_data_i(rsp_blk_i),
    .rdata_o(blk_rdata),
    .flat_o(req_blk_o),
    .idx_o(idx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0; cmd_q <= '0; adr_q <= '0;
    end else begin
      if (wr_ctl && !busy_w) ctl_q <= reg_wdata_i;
      if (reg_wr_i && off == OFF_CMD) cmd_q <= reg_wdata_i;
      if (reg_wr_i && off == OFF_ADR) adr_q <= reg_wdata_i;
    end
  end

  // completion results win over a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d0_q <= '0; d1_q <= '0;
    end else if (ok_rd) begin
      unique case (ctl_q[4:2])
        PR_SRBYTE, PR_BYTE: d0_q <= rsp_data_i[7:0];
        PR_WORD: begin d0_q <= rsp_data_i[7:0]; d1_q <= rsp_data_i[15:8]; end
        PR_BLOCK: d0_q <= rsp_count_i;
        default: ;
      endcase
    end else begin
      if (reg_wr_i && off == OFF_D0) d0_q <= reg_wdata_i;
      if (reg_wr_i && off == OFF_D1) d1_q <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0; err_q <= 1'b0;
    end else if (bad_w) begin
      done_q <= 1'b0; err_q <= 1'b1;
    end else if (start_w) begin
      done_q <= 1'b0; err_q <= 1'b0;
    end else if (fin_w) begin
      done_q <= !rsp_err_i; err_q <= rsp_err_i;
    end else if (wr_sts) begin
      done_q <= 1'b0; err_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (off)
      OFF_STS: reg_rdata_o = {5'b0, err_q, done_q, busy_w};
      OFF_CTL: reg_rdata_o = {3'b0, ctl_q[4:0]};
      OFF_CMD: reg_rdata_o = cmd_q;
      OFF_ADR: reg_rdata_o = adr_q;
      OFF_D0:  reg_rdata_o = d0_q;
      OFF_D1:  reg_rdata_o = d1_q;
      OFF_BLK: reg_rdata_o = blk_rdata;
      default: reg_rdata_o = '0;
    endcase
  end

  assign req_addr_o  = adr_q[7:1];
  assign req_read_o  = adr_q[0];
  assign req_proto_o = ctl_q[4:2];
  assign req_cmd_o   = cmd_q;
  assign req_data_o  = {d1_q, d0_q};
  assign req_count_o = d0_q;
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              rsp_valid_i,
  input logic              busy,
  input logic              err,
  input logic [IDX_W-1:0]  idx
);
  logic ctl_start, bad_code;
  assign ctl_start = reg_wr_i && reg_addr_i[5:0] == 6'd2 && reg_wdata_i[6] && !busy;
  assign bad_code  = reg_wdata_i[4:2] == 3'd4 || reg_wdata_i[4:2] == 3'd6 ||
                     reg_wdata_i[4:2] == 3'd7;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o); // R3
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> !req_valid_o); // R3
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_start && !bad_code |=> busy && req_valid_o); // R2
  AST_BAD_PROTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_start && bad_code |=> err && !busy && !req_valid_o); // R9
  AST_RSP_FIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !req_valid_o && rsp_valid_i |=> !busy); // R4
  AST_CTL_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && reg_addr_i[5:0] == 6'd2 |-> reg_rdata_o[7:5] == 3'b0); // R8
  AST_IDX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i[5:0] == 6'd0 |=> idx == '0); // R8
endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i),
  .busy(busy_w), .err(err_q), .idx(idx_w)
);

// File: tb/smb_host_regs_tb.sv
module smb_host_regs_tb;
  localparam int BLK_W = 256;

  logic clk_i = 0, rst_ni = 0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [7:0] reg_addr_i = 0, reg_wdata_i = 0, reg_rdata_o;
  logic req_valid_o, req_ready_i = 0, req_read_o;
  logic [6:0] req_addr_o;
  logic [2:0] req_proto_o;
  logic [7:0] req_cmd_o, req_count_o;
  logic [15:0] req_data_o;
  logic [BLK_W-1:0] req_blk_o;
  logic rsp_valid_i = 0, rsp_err_i = 0;
  logic [15:0] rsp_data_i = 0;
  logic [7:0] rsp_count_i = 0;
  logic [BLK_W-1:0] rsp_blk_i = 0;

  smb_host_regs u_dut (.*);

  always #2 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // target model
  int ready_delay = 1;
  int m_cnt = 0;
  logic [6:0] m_addr; logic m_rd; logic [2:0] m_proto;
  logic [7:0] m_cmd, m_count; logic [15:0] m_data; logic [BLK_W-1:0] m_blk;
  logic m_drop_ok = 1;

  initial begin
    forever begin
      @(negedge clk_i);
      if (req_valid_o) begin
        repeat (ready_delay) @(negedge clk_i);
        m_cnt++;
        m_addr = req_addr_o; m_rd = req_read_o; m_proto = req_proto_o;
        m_cmd = req_cmd_o; m_data = req_data_o; m_count = req_count_o; m_blk = req_blk_o;
        req_ready_i = 1;
        @(negedge clk_i);
        req_ready_i = 0;
        m_drop_ok = !req_valid_o;
        rsp_err_i = !(m_addr == 7'h50 || m_addr == 7'h21);
        rsp_data_i = {~m_cmd, m_cmd ^ {1'b0, m_addr}};
        rsp_count_i = 8'd5;
        for (int i = 0; i < 32; i++) rsp_blk_i[i*8 +: 8] = 8'h40 + 8'(i);
        rsp_valid_i = 1;
        @(negedge clk_i);
        rsp_valid_i = 0;
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_rd_i = 1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v); chk("R11 status", v, 0);
    rd(2, v); chk("R11 control", v, 0);
    rd(5, v); chk("R11 data0", v, 0);
    chk("R11 req_valid", req_valid_o, 0);
  endtask

  task automatic t_map();
    logic [7:0] v;
    wr(3, 8'h5A); rd(3 + 64, v); chk("R1 alias cmd", v, 8'h5A);
    rd(1, v); chk("R1 offset1", v, 0);
    wr(4 + 128, 8'hA0); rd(4, v); chk("R1 alias addr", v, 8'hA0);
    rd(12, v); chk("R1 offset12", v, 0);
  endtask

  task automatic t_wbyte();
    logic [7:0] v;
    wr(4, 8'hA0); wr(3, 8'h11); wr(5, 8'h77); wr(2, 8'h48);
    wait_idle();
    chk("R2 proto", m_proto, 2); chk("R2 addr", m_addr, 7'h50);
    chk("R2 dir", m_rd, 0); chk("R2 cmd", m_cmd, 8'h11);
    chk("R2 data", m_data[7:0], 8'h77);
    chk("R3 valid drop", m_drop_ok, 1);
    rd(0, v); chk("R4 done", v, 8'h02);
    rd(5, v); chk("R5 write keeps data0", v, 8'h77);
  endtask

  task automatic t_reads();
    logic [7:0] v;
    wr(4, 8'hA1); wr(3, 8'h22); wr(2, 8'h48); wait_idle();
    rd(5, v); chk("R5 byte read", v, 8'h72);
    wr(3, 8'h0F); wr(2, 8'h4C); wait_idle();
    rd(5, v); chk("R5 word low", v, 8'h5F);
    rd(6, v); chk("R5 word high", v, 8'hF0);
    wr(3, 8'h33); wr(2, 8'h44); wait_idle();
    chk("R2 recv proto", m_proto, 1);
    rd(5, v); chk("R5 receive", v, 8'h63);
  endtask

  task automatic t_errs();
    logic [7:0] v; int c;
    wr(4, 8'h66); wr(2, 8'h40); wait_idle();
    rd(0, v); chk("R4 absent err", v, 8'h04);
    wr(0, 0); rd(0, v); chk("R8 status clear", v, 0);
    c = m_cnt;
    wr(4, 8'hA0); wr(2, 8'h50);
    rd(0, v); chk("R9 unsupported err", v, 8'h04);
    repeat (4) @(negedge clk_i);
    chk("R9 no request", m_cnt, c);
    wr(2, 8'hA4); rd(2, v); chk("R8 ctl read mask", v, 8'h04);
    rd(0, v); chk("R8 no start without bit6", v, 8'h04);
  endtask

  task automatic t_blkidx();
    logic [7:0] v;
    wr(0, 0);
    for (int i = 0; i < 32; i++) wr(7, 8'h80 + 8'(i));
    wr(0, 0);
    for (int i = 0; i < 32; i++) begin
      rd(7, v); chk("R7 buffer byte", v, 8'h80 + i);
    end
    rd(7, v); chk("R7 wrap", v, 8'h80);
    rd(7, v); rd(7, v); rd(5, v);
    rd(7, v); chk("R7 other reg keeps index", v, 8'h83);
    rd(2, v); rd(7, v); chk("R8 ctl read resets index", v, 8'h80);
  endtask

  task automatic t_block();
    logic [7:0] v;
    wr(4, 8'hA0); wr(5, 8'd6); wr(2, 8'h54); wait_idle();
    chk("R6 proto", m_proto, 5); chk("R6 count", m_count, 6);
    chk("R6 payload", m_blk[3*8 +: 8], 8'h83);
    wr(4, 8'h43); wr(2, 8'h54); wait_idle();
    rd(5, v); chk("R6 read count", v, 5);
    rd(2, v);
    for (int i = 0; i < 5; i++) begin
      rd(7, v); chk("R6 read payload", v, 8'h40 + i);
    end
  endtask

  task automatic t_busy();
    logic [7:0] v; int c;
    ready_delay = 8; c = m_cnt;
    wr(4, 8'hA0); wr(2, 8'h48);
    repeat (3) @(negedge clk_i);
    chk("R3 valid held", req_valid_o, 1);
    rd(0, v); chk("R3 busy", v[0], 1);
    wr(2, 8'h54);
    wait_idle();
    rd(2, v); chk("R10 ctl kept", v, 8'h08);
    repeat (6) @(negedge clk_i);
    chk("R10 one request", m_cnt, c + 1);
    ready_delay = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset(); t_map(); t_wbyte(); t_reads(); t_errs();
    t_blkidx(); t_block(); t_busy();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule